// File: doc/BRIEF.md
# Serial Register Port with Bidirectional Data Line

This block is a three-wire slave that gives a host access to a bank of sixteen 8-bit registers. The host raises an enable, runs a serial clock and moves data over a single data line. The line appears at the block boundary as a pad-side triple: an input, an output and an output enable. Every frame is sixteen bits long and is sampled on rising clock edges. The first byte carries the instruction, a bank select and the register address. The second byte carries write data, or it is the window in which the slave returns read data.

All frame logic runs on the serial clock. The register file is also clocked by the serial clock, so a write lands on the sixteenth edge with no help from the core clock. Each committed write sends a toggle into the core clock domain. There it becomes a one-cycle strobe, together with the address that was written. Some addresses are read-only: they return a value supplied by the core and cannot be written. Others are write-only: they read back as zero.

Top module: `sreg_port`

## Requirements
- R1: While `rst_n` is low, and immediately after it rises, `reg_q` is all zero, `sdo_en` is low and `wr_stb` is low.
- R2: Frame bits are taken LSB first, one per rising `sclk` edge while `sen` is high. Bit 0 is the instruction (0 = write, 1 = read). Bits 3:1 are the bank select. Bits 7:4 are the address. Bits 15:8 are the data byte. A valid write stores the data byte in the addressed register, which appears on `reg_q[8*a +: 8]`.
- R3: A write commits on the 16th rising edge and not before. If `sen` falls before that edge, the frame leaves no trace: no register changes and no strobe is issued.
- R4: Rising edges after the 16th in the same enable window are ignored. They neither shift data nor change any register.
- R5: If a frame's bank select is not `BANK_ID` (default 3'b111), it writes nothing and `sdo_en` stays low for the whole frame.
- R6: In a valid read frame, `sdo_en` rises on the falling edge after the 8th rising edge. It falls on the falling edge after the 16th rising edge, and at once whenever `sen` is low. At no other time is it high.
- R7: In a read frame, data bit k appears on `sdo` from the falling edge after rising edge 8+k. Read values are defined by the address: a writable address returns its stored value; an address set in `RO_MASK` (default 12 to 15) returns its slice of `ro_vals`, sampled at the falling edge after the 8th rising edge; an address set in `WO_MASK` (default 0 to 3) returns 0.
- R8: Writes to addresses in `RO_MASK` are ignored. Their `reg_q` slices stay zero, and no strobe is issued for them.
- R9: Every committed write produces exactly one single-cycle `wr_stb` pulse within four `clk` cycles of the 16th edge. While the pulse is high, `wr_addr` holds the written address.
- R10: A read frame changes no register and issues no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock for the write strobe |
| rst_n | input | 1 | Asynchronous active-low reset of all state |
| sclk | input | 1 | Serial clock; data sampled on rising edge |
| sen | input | 1 | Active-high frame enable |
| sdi | input | 1 | Data line, pad input side |
| sdo | output | 1 | Data line, pad output side |
| sdo_en | output | 1 | Pad output enable for the data line |
| ro_vals | input | 128 | Core-supplied values for read-only addresses, 8 bits per address |
| reg_q | output | 128 | Contents of the register file, 8 bits per address |
| wr_stb | output | 1 | One-cycle pulse in the core domain per committed write |
| wr_addr | output | 4 | Address of the latest committed write |

## Verification
The commit on the 16th rising edge and the fall of the enable can land close together. That boundary decides whether a frame counts. The bench drops the enable one edge short of a full frame, and also right after a full frame, and runs frames well past sixteen edges. After each case, a behavioural register image, updated only on the 16th edge of a valid write, is compared with `reg_q` on every core clock. The number of core strobes seen is also compared with the number the model predicts. In read frames, `sdo_en` and `sdo` are sampled just before each rising edge, against the window and the bit order.

// File: rtl/sreg_port_pkg.sv
package sreg_port_pkg;

  localparam int DATA_W    = 8;
  localparam int HDR_W     = 8;
  localparam int ADDR_W    = 4;
  localparam int BANK_W    = 3;
  localparam int NREG      = 1 << ADDR_W;
  localparam int FRAME_LEN = HDR_W + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int IDX_W     = $clog2(DATA_W);

  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);

  // Header as received: bit 0 first on the wire.
  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [BANK_W-1:0] bank;
    logic              rd;
  } hdr_t;

  function automatic logic may_write(hdr_t h, logic [BANK_W-1:0] id, logic ro);
    return !h.rd && (h.bank == id) && !ro;
  endfunction

  function automatic logic may_read(hdr_t h, logic [BANK_W-1:0] id);
    return h.rd && (h.bank == id);
  endfunction

  function automatic logic [DATA_W-1:0] read_pick(logic ro, logic wo,
                                                  logic [DATA_W-1:0] stored,
                                                  logic [DATA_W-1:0] ext);
    if (ro) return ext;
    if (wo) return '0;
    return stored;
  endfunction

  // The last data bit is still on the line at the committing edge.
  function automatic logic [DATA_W-1:0] with_last_bit(logic [DATA_W-1:0] dat, logic bit_in);
    return {bit_in, dat[DATA_W-2:0]};
  endfunction

endpackage

// File: rtl/sreg_port_frame.sv
module sreg_port_frame
  import sreg_port_pkg::*;
(
  input  logic             sclk,
  input  logic             frm_rst_n,
  input  logic             sdi,
  output logic [CNT_W-1:0] cnt,
  output hdr_t             hdr,
  output logic [DATA_W-1:0] dat
);

  logic [HDR_W-1:0] hdr_q;

  always_ff @(posedge sclk or negedge frm_rst_n) begin
    if (!frm_rst_n) begin
      cnt   <= '0;
      hdr_q <= '0;
      dat   <= '0;
    end else if (cnt < CNT_FULL) begin
      cnt <= cnt + 1'b1;
      if (cnt < CNT_HDR) hdr_q[cnt[IDX_W-1:0]] <= sdi;
      else               dat[cnt[IDX_W-1:0]]   <= sdi;
    end
  end

  assign hdr = hdr_t'(hdr_q);

endmodule

// File: rtl/sreg_port_bank.sv
module sreg_port_bank
  import sreg_port_pkg::*;
#(
  parameter logic [NREG-1:0] RO_MASK = 16'hF000,
  parameter logic [NREG-1:0] WO_MASK = 16'h000F
) (
  input  logic                     sclk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [ADDR_W-1:0]        raddr,
  input  logic [NREG*DATA_W-1:0]   ro_vals,
  output logic [NREG*DATA_W-1:0]   reg_q,
  output logic [DATA_W-1:0]        rdata
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (RO_MASK[g]) begin : g_ro
      assign reg_q[g*DATA_W +: DATA_W] = '0;
    end else begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n)                                q <= '0;
        else if (wr_en && (waddr == ADDR_W'(g)))   q <= wdata;
      end
      assign reg_q[g*DATA_W +: DATA_W] = q;
    end
  end

  assign rdata = read_pick(RO_MASK[raddr], WO_MASK[raddr],
                           reg_q[raddr*DATA_W +: DATA_W],
                           ro_vals[raddr*DATA_W +: DATA_W]);

endmodule

// File: rtl/sreg_port_tx.sv
module sreg_port_tx
  import sreg_port_pkg::*;
(
  input  logic              sclk,
  input  logic              frm_rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              rd_ok,
  input  logic [DATA_W-1:0] rdata,
  output logic              sdo,
  output logic              sdo_en
);

  logic [DATA_W-1:0] sh;

  always_ff @(negedge sclk or negedge frm_rst_n) begin
    if (!frm_rst_n) begin
      sh     <= '0;
      sdo_en <= 1'b0;
    end else if (cnt == CNT_HDR) begin
      sh     <= rdata;
      sdo_en <= rd_ok;
    end else if (cnt == CNT_FULL) begin
      sdo_en <= 1'b0;
    end else if (sdo_en) begin
      sh <= sh >> 1;
    end
  end

  assign sdo = sh[0];

endmodule

// File: rtl/sreg_port_wsync.sv
module sreg_port_wsync
  import sreg_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              sclk,
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [ADDR_W-1:0] waddr,
  output logic              cmt_tgl,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr
);

  logic [SYNC_STAGES:0] chain;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      cmt_tgl <= 1'b0;
      wr_addr <= '0;
    end else if (commit) begin
      cmt_tgl <= ~cmt_tgl;
      wr_addr <= waddr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[SYNC_STAGES-1:0], cmt_tgl};
  end

  assign wr_stb = chain[SYNC_STAGES] ^ chain[SYNC_STAGES-1];

endmodule

// File: rtl/sreg_port.sv
module sreg_port
  import sreg_port_pkg::*;
#(
  parameter logic [BANK_W-1:0] BANK_ID     = '1,
  parameter logic [NREG-1:0]   RO_MASK     = 16'hF000,
  parameter logic [NREG-1:0]   WO_MASK     = 16'h000F,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sclk,
  input  logic                   sen,
  input  logic                   sdi,
  output logic                   sdo,
  output logic                   sdo_en,
  input  logic [NREG*DATA_W-1:0] ro_vals,
  output logic [NREG*DATA_W-1:0] reg_q,
  output logic                   wr_stb,
  output logic [ADDR_W-1:0]      wr_addr
);

  // Frame state lives only while the enable is high.
  logic frm_rst_n;
  assign frm_rst_n = rst_n & sen;

  logic [CNT_W-1:0]  cnt;
  hdr_t              hdr;
  logic [DATA_W-1:0] dat;

  sreg_port_frame u_frame (
    .sclk      (sclk),
    .frm_rst_n (frm_rst_n),
    .sdi       (sdi),
    .cnt       (cnt),
    .hdr       (hdr),
    .dat       (dat)
  );

  // Named events for the checker.
  logic              wr_en;
  logic              rd_ok;
  logic              cmt_tgl;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;

  assign wr_en = (cnt == CNT_LAST) && may_write(hdr, BANK_ID, RO_MASK[hdr.addr]);
  assign rd_ok = may_read(hdr, BANK_ID);
  assign wdata = with_last_bit(dat, sdi);

  sreg_port_bank #(
    .RO_MASK (RO_MASK),
    .WO_MASK (WO_MASK)
  ) u_bank (
    .sclk    (sclk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .waddr   (hdr.addr),
    .wdata   (wdata),
    .raddr   (hdr.addr),
    .ro_vals (ro_vals),
    .reg_q   (reg_q),
    .rdata   (rdata)
  );

  sreg_port_tx u_tx (
    .sclk      (sclk),
    .frm_rst_n (frm_rst_n),
    .cnt       (cnt),
    .rd_ok     (rd_ok),
    .rdata     (rdata),
    .sdo       (sdo),
    .sdo_en    (sdo_en)
  );

  sreg_port_wsync #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_wsync (
    .sclk    (sclk),
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (wr_en),
    .waddr   (hdr.addr),
    .cmt_tgl (cmt_tgl),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr)
  );

endmodule

// File: rtl/sreg_port_chk.sv
module sreg_port_chk
  import sreg_port_pkg::*;
#(
  parameter logic [BANK_W-1:0] BANK_ID = '1
) (
  input logic             sclk,
  input logic             clk,
  input logic             rst_n,
  input logic             sen,
  input logic [CNT_W-1:0] cnt,
  input hdr_t             hdr,
  input logic             wr_en,
  input logic             cmt_tgl,
  input logic             sdo_en,
  input logic             wr_stb
);

  AST_DRIVE_WINDOW: assert property (@(posedge sclk) disable iff (!rst_n)
    sdo_en |-> (cnt >= CNT_HDR && cnt < CNT_FULL)); // R6

  AST_DRIVE_VALID_READ: assert property (@(posedge sclk) disable iff (!rst_n)
    sdo_en |-> (hdr.rd && hdr.bank == BANK_ID)); // R5

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sen |-> !sdo_en); // R6

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R9

  AST_COMMIT_FLIPS: assert property (@(posedge sclk) disable iff (!rst_n)
    wr_en |=> !$stable(cmt_tgl)); // R3

  AST_NO_STRAY_COMMIT: assert property (@(posedge sclk) disable iff (!rst_n)
    !wr_en |=> $stable(cmt_tgl)); // R3

endmodule

bind sreg_port sreg_port_chk #(.BANK_ID(BANK_ID)) u_chk (
  .sclk    (sclk),
  .clk     (clk),
  .rst_n   (rst_n),
  .sen     (sen),
  .cnt     (cnt),
  .hdr     (hdr),
  .wr_en   (wr_en),
  .cmt_tgl (cmt_tgl),
  .sdo_en  (sdo_en),
  .wr_stb  (wr_stb)
);

// File: tb/sim_sreg_port.sv
`timescale 1ns/1ps
module sim_sreg_port;

  localparam logic [15:0] RO_M = 16'hF000;
  localparam logic [15:0] WO_M = 16'h000F;

  logic clk = 1'b0;
  logic rst_n, sclk, sen, sdi;
  logic sdo, sdo_en, wr_stb;
  logic [127:0] ro_vals, reg_q;
  logic [3:0] wr_addr;

  always #10 clk = ~clk;

  sreg_port u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sen(sen), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en), .ro_vals(ro_vals), .reg_q(reg_q),
    .wr_stb(wr_stb), .wr_addr(wr_addr)
  );

  int checks = 0;
  int fails  = 0;
  int exp_stb = 0;
  int got_stb = 0;
  logic [7:0] mdl [16];
  logic [3:0] last_addr = '0;
  bit running = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] image();
    logic [127:0] v;
    for (int a = 0; a < 16; a++) v[a*8 +: 8] = mdl[a];
    return v;
  endfunction

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    if (RO_M[a]) return ro_vals[a*8 +: 8];
    if (WO_M[a]) return 8'h00;
    return mdl[a];
  endfunction

  // Register image compared on every core clock: R2 R3 R4 R8 R10
  always @(negedge clk) begin
    if (running) chk(reg_q == image(), "R2/R3/R4/R8/R10 register image", reg_q, image());
  end

  // Strobe monitor: R9
  always @(negedge clk) begin
    if (running && wr_stb) begin
      got_stb++;
      chk(wr_addr == last_addr, "R9 strobe address", 128'(wr_addr), 128'(last_addr));
    end
  end

  task automatic line_chk(input int n, input bit rdok, input logic [7:0] rv);
    bit eoe;
    eoe = rdok && n >= 8 && n <= 15;
    chk(sdo_en == eoe, "R5/R6 drive window", 128'(sdo_en), 128'(eoe));
    if (eoe) chk(sdo == rv[n-8], "R7 read bit", 128'(sdo), 128'(rv[n-8]));
  endtask

  task automatic frame(input bit rd, input logic [2:0] bank, input logic [3:0] addr,
                       input logic [7:0] data, input int nedge);
    logic [15:0] v;
    bit rdok;
    logic [7:0] rv;
    v    = {data, addr, bank, rd};
    rdok = rd && (bank == 3'b111);
    rv   = exp_read(addr);
    @(negedge clk); #5;
    sen = 1'b1; #20;
    for (int i = 0; i < nedge; i++) begin
      sclk = 1'b0;
      sdi  = (i < 16) ? v[i] : ~sdi;
      #15; line_chk(i, rdok, rv); #5;
      sclk = 1'b1;
      if (i == 15 && !rd && bank == 3'b111 && !RO_M[addr]) begin
        mdl[addr] = data;
        last_addr = addr;
        exp_stb++;
      end
      #20;
    end
    sclk = 1'b0; #15; line_chk(nedge, rdok, rv); #5;
    sen = 1'b0; sdi = 1'b0; #15;
    chk(sdo_en == 1'b0, "R6 released with enable low", 128'(sdo_en), 128'(0));
    repeat (6) @(negedge clk);
    #1;
    chk(got_stb == exp_stb, "R9 R10 strobe count", 128'(got_stb), 128'(exp_stb));
  endtask

  initial begin
    rst_n = 1'b0; sclk = 1'b0; sen = 1'b0; sdi = 1'b0;
    for (int a = 0; a < 16; a++) begin
      mdl[a] = 8'h00;
      ro_vals[a*8 +: 8] = 8'h90 + 8'(a);
    end
    repeat (3) @(negedge clk);
    chk(reg_q == '0, "R1 reset image", reg_q, '0);
    chk(sdo_en == 1'b0, "R1 reset drive", 128'(sdo_en), 128'(0));
    chk(wr_stb == 1'b0, "R1 reset strobe", 128'(wr_stb), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(reg_q == '0 && !wr_stb, "R1 after reset", reg_q, '0);
    running = 1'b1;

    frame(1'b0, 3'b111, 4'd4, 8'h5A, 16);   // R2 write
    frame(1'b1, 3'b111, 4'd4, 8'h00, 16);   // R7 R10 read back
    frame(1'b0, 3'b111, 4'd9, 8'hC3, 16);
    frame(1'b1, 3'b111, 4'd9, 8'hFF, 16);
    frame(1'b0, 3'b111, 4'd2, 8'h77, 16);   // write-only target
    frame(1'b1, 3'b111, 4'd2, 8'h00, 16);   // R7 reads zero
    frame(1'b0, 3'b111, 4'd13, 8'h11, 16);  // R8 ignored
    frame(1'b1, 3'b111, 4'd13, 8'h00, 16);  // R7 core value
    ro_vals[14*8 +: 8] = 8'h3C;
    frame(1'b1, 3'b111, 4'd14, 8'h00, 16);
    frame(1'b0, 3'b101, 4'd5, 8'hFF, 16);   // R5 bank mismatch
    frame(1'b1, 3'b011, 4'd4, 8'h00, 16);   // R5 no drive
    frame(1'b0, 3'b111, 4'd4, 8'h00, 15);   // R3 abort one short
    frame(1'b1, 3'b111, 4'd9, 8'h00, 12);   // R6 abort mid read
    frame(1'b0, 3'b111, 4'd6, 8'h3C, 20);   // R4 overlong write
    frame(1'b1, 3'b111, 4'd6, 8'h00, 20);   // R4 R6 overlong read
    frame(1'b0, 3'b111, 4'd7, 8'h81, 16);   // back to back
    frame(1'b0, 3'b111, 4'd8, 8'h18, 16);
    frame(1'b1, 3'b111, 4'd7, 8'h00, 16);

    running = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule